// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock with Alarm

This core keeps wall-clock time as a 32-bit count of seconds in a slow clock domain of about 32 kHz. A prescaler divides the input clock down to a one-second tick. The reload value of the prescaler is programmable and holds the number of input cycles per second minus one. Each tick advances the seconds count and raises a one-second flag. An alarm comparator raises an alarm flag when the count matches a programmed alarm value. One interrupt output combines the two flags, each gated by its own enable.

Software reaches the core through a plain 32-bit register port with word addresses. Writes are protected in two ways. First, software writes the key value 0xA55A to the key register, which arms the port. The next write to any other register is then accepted and consumes the arming. Second, every accepted write takes the port busy for a fixed time, and the write-ready bit reads 0 during that time. A small state machine enforces this. In LOCKED the port is ready and not armed. A key write moves it to ARMED (transition *arm*). In ARMED a write to any other register commits and moves it to BUSY (transition *commit*). BUSY returns to LOCKED after the busy time (transition *release*). Every other write is dropped. A scratch word with no function of its own is also provided.

Top module: `rtc_core`

## Requirements
- R1: After reset the control register reads 0x0000_0080, seconds and alarm read 0, prescaler reads 32767, scratch and key read 0, and irq is 0.
- R2: A write to word 15 with low half 0xA55A, made while ready, sets bit 31 of word 15. Any other value leaves bit 31 at 0.
- R3: A write to any register other than word 15 changes it only if the port is ready and armed. Otherwise every register keeps its value.
- R4: After an accepted write, control bit 7 (ready) reads 0 for exactly 4 cycles and then reads 1, and word 15 bit 31 reads 0.
- R5: While control bit 0 (run) is 1, the seconds count (word 1) increases by one every reload+1 cycles, where reload is word 3.
- R6: While run is 0, the seconds count holds. When running, it wraps from 0xFFFFFFFF to 0.
- R7: A write to word 1 loads the written value and restarts the prescaler. The first increment follows reload+1 cycles after the write.
- R8: Control bit 6 is set on each tick. Writing 0 to bit 6 clears it and writing 1 keeps it. A tick in the same cycle wins.
- R9: Control bit 4 is set whenever bit 2 (alarm enable) is 1 and the seconds count equals word 2. It is never set while bit 2 is 0. Writing 0 clears it and writing 1 keeps it.
- R10: irq equals (bit 6 AND bit 5) OR (bit 4 AND bit 3) of the control register.
- R11: Word 13 returns the last value accepted for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow time-keeping clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 4 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The key-and-ready gating is tried with writes made while unarmed, with a wrong key, during the busy window, and with a correct sequence. This separates a missing key check from a missing busy check. Counting is tried with a short reload, with run on and off, with a reload of the count just before the tick, and across the 32-bit wrap. These runs catch off-by-one errors in the prescaler period and a lost restart. The flags are written with 0 and with 1 both before and after they are set, and the alarm is armed and disarmed at a matching count. This separates clear-on-0 from clear-on-write and shows whether the alarm enable gates the compare.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_SECS  = 4'd1;
    localparam logic [ADDR_W-1:0] A_ALARM = 4'd2;
    localparam logic [ADDR_W-1:0] A_RELD  = 4'd3;
    localparam logic [ADDR_W-1:0] A_SCR   = 4'd13;
    localparam logic [ADDR_W-1:0] A_KEY   = 4'd15;

    localparam logic [15:0] KEY_VALUE = 16'hA55A;

    localparam int unsigned B_RUN   = 0;
    localparam int unsigned B_AEN   = 2;
    localparam int unsigned B_AIE   = 3;
    localparam int unsigned B_AFLG  = 4;
    localparam int unsigned B_SIE   = 5;
    localparam int unsigned B_SFLG  = 6;
    localparam int unsigned B_READY = 7;
    localparam int unsigned B_ARMED = 31;

    typedef enum logic [1:0] {
        GS_LOCKED = 2'd0,
        GS_ARMED  = 2'd1,
        GS_BUSY   = 2'd2
    } gate_state_e;
endpackage

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate
    import rtc_pkg::*;
#(
    parameter int unsigned BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic key_addr,
    input  logic key_ok,
    output logic ready,
    output logic armed,
    output logic commit
);
    localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BUSY_CYCLES - 1);

    gate_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            GS_LOCKED: begin
                if (wr && key_addr && key_ok) begin
                    state_d = GS_ARMED;               // arm
                end
            end
            GS_ARMED: begin
                if (wr && !key_addr) begin
                    state_d = GS_BUSY;                // commit
                    cnt_d   = '0;
                end
            end
            GS_BUSY: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = GS_LOCKED;              // release
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = GS_LOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_LOCKED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        ready  = 1'b0;
        armed  = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            GS_LOCKED: ready = 1'b1;
            GS_ARMED: begin
                ready  = 1'b1;
                armed  = 1'b1;
                commit = wr && !key_addr;
            end
            GS_BUSY: ready = 1'b0;
            default: ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] reload,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q;

    assign tick = run && !restart && (cnt_q >= reload);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
    parameter int unsigned SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEC_W-1:0] load_val,
    input  logic             step,
    input  logic [SEC_W-1:0] match_val,
    output logic [SEC_W-1:0] count,
    output logic             match
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end

    assign match = (count == match_val);
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int unsigned PRE_W       = 16,
    parameter int unsigned RELOAD_INIT = 32767,
    parameter int unsigned BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic ready, armed, commit, tick, hit;
    logic ctrl_wr, sec_load;
    logic run_q, aen_q, aie_q, sie_q, sflg_q, aflg_q;
    logic [DATA_W-1:0] sec_q, alarm_q, scr_q;
    logic [PRE_W-1:0]  reload_q;

    rtc_wr_gate #(.BUSY_CYCLES(BUSY_CYCLES)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .key_addr (reg_addr == A_KEY),
        .key_ok   (reg_wdata[15:0] == KEY_VALUE),
        .ready    (ready),
        .armed    (armed),
        .commit   (commit)
    );

    assign ctrl_wr  = commit && (reg_addr == A_CTRL);
    assign sec_load = commit && (reg_addr == A_SECS);

    rtc_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .restart (sec_load),
        .reload  (reload_q),
        .tick    (tick)
    );

    rtc_seconds #(.SEC_W(DATA_W)) u_sec (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sec_load),
        .load_val  (reg_wdata),
        .step      (tick),
        .match_val (alarm_q),
        .count     (sec_q),
        .match     (hit)
    );

    // control fields and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            aen_q  <= 1'b0;
            aie_q  <= 1'b0;
            sie_q  <= 1'b0;
            sflg_q <= 1'b0;
            aflg_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                run_q <= reg_wdata[B_RUN];
                aen_q <= reg_wdata[B_AEN];
                aie_q <= reg_wdata[B_AIE];
                sie_q <= reg_wdata[B_SIE];
            end
            sflg_q <= (ctrl_wr ? (sflg_q & reg_wdata[B_SFLG]) : sflg_q) | tick;
            aflg_q <= (ctrl_wr ? (aflg_q & reg_wdata[B_AFLG]) : aflg_q) | (aen_q & hit);
        end
    end

    // data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q  <= '0;
            scr_q    <= '0;
            reload_q <= PRE_W'(RELOAD_INIT);
        end else if (commit) begin
            if (reg_addr == A_ALARM) alarm_q  <= reg_wdata;
            if (reg_addr == A_SCR)   scr_q    <= reg_wdata;
            if (reg_addr == A_RELD)  reload_q <= reg_wdata[PRE_W-1:0];
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[B_READY] = ready;
                reg_rdata[B_SFLG]  = sflg_q;
                reg_rdata[B_SIE]   = sie_q;
                reg_rdata[B_AFLG]  = aflg_q;
                reg_rdata[B_AIE]   = aie_q;
                reg_rdata[B_AEN]   = aen_q;
                reg_rdata[B_RUN]   = run_q;
            end
            A_SECS:  reg_rdata = sec_q;
            A_ALARM: reg_rdata = alarm_q;
            A_RELD:  reg_rdata[PRE_W-1:0] = reload_q;
            A_SCR:   reg_rdata = scr_q;
            A_KEY:   reg_rdata[B_ARMED] = armed;
            default: reg_rdata = '0;
        endcase
    end

    assign irq = (sflg_q & sie_q) | (aflg_q & aie_q);
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
    parameter int unsigned BUSY_CYCLES = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ready,
    input logic        armed,
    input logic        commit,
    input logic        tick,
    input logic        sec_load,
    input logic        run,
    input logic        aen,
    input logic        hit,
    input logic        sflg,
    input logic        aflg,
    input logic [31:0] sec
);
    logic [7:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_cnt <= '0;
        else        low_cnt <= ready ? 8'd0 : low_cnt + 8'd1;
    end

    p_commit_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (ready && armed));

    p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (low_cnt < 8'(BUSY_CYCLES)));

    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (low_cnt == 8'(BUSY_CYCLES)));

    p_busy_after_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (!ready && !armed));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !sec_load) |=> (sec == $past(sec) + 32'd1));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !sec_load) |=> $stable(sec));

    p_sflag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> sflg);

    p_alarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (aen && hit) |=> aflg);

    p_alarm_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aflg) |-> $past(aen && hit));
endmodule

bind rtc_core rtc_core_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .armed    (armed),
    .commit   (commit),
    .tick     (tick),
    .sec_load (sec_load),
    .run      (run_q),
    .aen      (aen_q),
    .hit      (hit),
    .sflg     (sflg_q),
    .aflg     (aflg_q),
    .sec      (sec_q)
);

// File: tb/sim_rtc_core.sv
`timescale 1ns/100ps
module sim_rtc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    always #2.5 clk = ~clk;

    rtc_core u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // behavioural reference model
    logic [31:0] m_sec, m_alarm, m_scr;
    int unsigned m_reload, m_phase, m_busy;
    bit m_armed, m_run, m_aen, m_aie, m_sie, m_sflg, m_aflg;

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0:  return {24'd0, (m_busy == 0), m_sflg, m_sie, m_aflg, m_aie, m_aen, 1'b0, m_run};
            4'd1:  return m_sec;
            4'd2:  return m_alarm;
            4'd3:  return m_reload;
            4'd13: return m_scr;
            4'd15: return {m_armed, 31'd0};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sec = 0; m_alarm = 0; m_scr = 0; m_reload = 32767; m_phase = 0; m_busy = 0;
            m_armed = 0; m_run = 0; m_aen = 0; m_aie = 0; m_sie = 0; m_sflg = 0; m_aflg = 0;
        end else begin
            bit rdy, acc, secw, tk, ah, cw;
            rdy  = (m_busy == 0);
            acc  = reg_wr && rdy && m_armed && (reg_addr != 4'd15);
            secw = acc && (reg_addr == 4'd1);
            cw   = acc && (reg_addr == 4'd0);
            tk   = m_run && !secw && (m_phase >= m_reload);
            ah   = m_aen && (m_sec == m_alarm);
            if (secw) m_phase = 0;
            else if (m_run) m_phase = tk ? 0 : m_phase + 1;
            if (secw) m_sec = reg_wdata;
            else if (tk) m_sec = m_sec + 1;
            m_sflg = (cw ? (m_sflg && reg_wdata[6]) : m_sflg) || tk;
            m_aflg = (cw ? (m_aflg && reg_wdata[4]) : m_aflg) || ah;
            if (cw) begin
                m_run = reg_wdata[0]; m_aen = reg_wdata[2];
                m_aie = reg_wdata[3]; m_sie = reg_wdata[5];
            end
            if (acc && reg_addr == 4'd2)  m_alarm  = reg_wdata;
            if (acc && reg_addr == 4'd13) m_scr    = reg_wdata;
            if (acc && reg_addr == 4'd3)  m_reload = reg_wdata[15:0];
            if (acc) begin
                m_busy = 4; m_armed = 0;
            end else begin
                if (m_busy > 0) m_busy = m_busy - 1;
                if (reg_wr && rdy && reg_addr == 4'd15 && reg_wdata[15:0] == 16'hA55A) m_armed = 1;
            end
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0:  return "R8 control";
            4'd1:  return "R5 seconds";
            4'd15: return "R2 key";
            4'd13: return "R11 scratch";
            default: return "R3 register";
        endcase
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (live && rst_n && !done) begin
            check({31'd0, irq}, {31'd0, (m_sflg && m_sie) || (m_aflg && m_aie)}, "R10 irq");
            check(reg_rdata, m_read(reg_addr), tag_of(reg_addr));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        idle(1);
        reg_wr = 1'b0;
    endtask

    task automatic keyed_write(input logic [3:0] a, input logic [31:0] d);
        bus_write(4'd15, 32'h0000_A55A);
        bus_write(a, d);
        idle(4);
    endtask

    task automatic peek(input logic [3:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #0.2;
        check(reg_rdata, exp, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        idle(3);
        rst_n = 1'b1;
        live = 1'b1;
        idle(1);
        // R1 reset state
        peek(4'd0, 32'h80, "R1 control");
        peek(4'd1, 32'd0, "R1 seconds");
        peek(4'd2, 32'd0, "R1 alarm");
        peek(4'd3, 32'd32767, "R1 reload");
        peek(4'd13, 32'd0, "R1 scratch");
        peek(4'd15, 32'd0, "R1 key");
        check({31'd0, irq}, 32'd0, "R1 irq");

        // R3 write without key is dropped
        bus_write(4'd13, 32'h1234);
        peek(4'd13, 32'd0, "R3 unarmed write ignored");
        peek(4'd0, 32'h80, "R3 ready unaffected");

        // R2 wrong key, then right key
        bus_write(4'd15, 32'h0000_1111);
        peek(4'd15, 32'd0, "R2 wrong key");
        bus_write(4'd15, 32'hFFFF_A55A);
        peek(4'd15, 32'h8000_0000, "R2 key accepted");

        // R4 busy window, R11 scratch
        bus_write(4'd13, 32'hCAFE_F00D);
        peek(4'd0, 32'h00, "R4 busy cycle 1");
        peek(4'd15, 32'd0, "R4 key consumed");
        for (int i = 2; i <= 4; i++) begin
            idle(1);
            peek(4'd0, 32'h00, "R4 busy window");
        end
        idle(1);
        peek(4'd0, 32'h80, "R4 ready again");
        peek(4'd13, 32'hCAFE_F00D, "R11 scratch");

        // R3 writes during busy are dropped
        bus_write(4'd15, 32'h0000_A55A);
        bus_write(4'd13, 32'h1);
        bus_write(4'd15, 32'h0000_A55A);
        bus_write(4'd13, 32'h2);
        idle(5);
        peek(4'd13, 32'h1, "R3 busy writes ignored");
        peek(4'd15, 32'd0, "R3 key during busy ignored");

        // R5/R7 counting with reload 3
        keyed_write(4'd3, 32'd3);
        peek(4'd3, 32'd3, "R3 reload written");
        keyed_write(4'd0, 32'h1);
        bus_write(4'd15, 32'h0000_A55A);
        bus_write(4'd1, 32'd100);
        peek(4'd1, 32'd100, "R7 load");
        idle(3);
        peek(4'd1, 32'd100, "R7 restart holds");
        idle(1);
        peek(4'd1, 32'd101, "R7 first step");
        idle(4);
        peek(4'd1, 32'd102, "R5 period");
        peek(4'd0, 32'hC1, "R8 flag set by tick");

        // R8 write 1 keeps, write 0 clears (run off so no tick can set it)
        keyed_write(4'd0, 32'h40);
        peek(4'd0, 32'hC0, "R8 write 1 keeps");
        keyed_write(4'd0, 32'h00);
        peek(4'd0, 32'h80, "R8 write 0 clears");

        // R6 hold while stopped
        peek(4'd1, m_sec, "R6 stopped value");
        held = reg_rdata;
        idle(12);
        peek(4'd1, held, "R6 hold");

        // R6 wrap
        keyed_write(4'd1, 32'hFFFF_FFFE);
        keyed_write(4'd0, 32'h1);
        idle(10);
        peek(4'd1, m_sec, "R6 after wrap");
        check({31'd0, reg_rdata < 32'd4}, 32'd1, "R6 wrapped to low value");

        // R9 alarm disabled: no flag
        keyed_write(4'd2, m_sec + 32'd2);
        idle(12);
        peek(4'd0, m_read(4'd0), "R9 disabled");
        check({31'd0, reg_rdata[4]}, 32'd0, "R9 no flag without enable");

        // R9/R10 alarm enabled
        keyed_write(4'd2, m_sec + 32'd8);
        keyed_write(4'd0, 32'h0D);
        idle(40);
        peek(4'd0, m_read(4'd0), "R9 alarm flag");
        check({31'd0, reg_rdata[4]}, 32'd1, "R9 flag set on match");
        check({31'd0, irq}, 32'd1, "R10 alarm irq");
        keyed_write(4'd0, 32'h1D);
        peek(4'd0, m_read(4'd0), "R9 write 1 keeps");
        check({31'd0, reg_rdata[4]}, 32'd1, "R9 kept");
        keyed_write(4'd0, 32'h0D);
        peek(4'd0, m_read(4'd0), "R9 write 0 clears");
        check({31'd0, reg_rdata[4]}, 32'd0, "R9 cleared");
        check({31'd0, irq}, 32'd0, "R10 irq drops");

        // R10 one-second interrupt
        keyed_write(4'd0, 32'h21);
        idle(6);
        check({31'd0, irq}, 32'd1, "R10 second irq");
        keyed_write(4'd0, 32'h01);
        check({31'd0, irq}, 32'd0, "R10 second irq disabled");
        idle(4);
        finish_run();
    end
endmodule